// File: doc/BRIEF.md
# 4x4 Hybrid Inverse Transform Reconstructor

This block rebuilds one 4x4 block of 8-bit pixels from sixteen signed 16-bit transform coefficients and a matching 4x4 block of prediction pixels. It runs a separable two-dimensional inverse transform. First every row is transformed, then every column. Each of the two passes uses either a 4-point inverse DCT or a 4-point inverse ADST, and a 2-bit type code picks which one each pass uses.

After the column pass, every residual gets a rounding shift down by four bits. It is then added to its prediction pixel, and the sum is clamped to the pixel range. A valid/ready handshake takes in one whole block with its type code and prediction. The block computes for eight cycles, then presents the finished block on a second valid/ready handshake. One 1-D transform unit serves both passes. A 16-entry intermediate buffer, written by rows and read by columns, does the transpose between the passes.

All matrices are flattened row-major: element (row r, column c) sits at index 4r+c. For the coefficients this is the 16-bit slice [16(4r+c) +: 16]. For the prediction and output pixels it is the 8-bit slice [8(4r+c) +: 8].

Top module: `iht4_recon`

## Requirements
- R1: Type code 0 applies the inverse DCT to the rows and again to the columns.
- R2: Type code 1 applies the inverse DCT to the rows and the inverse ADST to the columns.
- R3: Type code 2 applies the inverse ADST to the rows and the inverse DCT to the columns.
- R4: Type code 3 applies the inverse ADST in both passes.
- R5: Inverse DCT on inputs x0..x3. Let a = x0+x2 and b = x0-x2, both wrapping at 16 bits. Then s0 = R(11585a), s1 = R(11585b), s2 = R(6270x1 - 15137x3) and s3 = R(15137x1 + 6270x3). The outputs are y0 = s0+s3, y1 = s1+s2, y2 = s1-s2 and y3 = s0-s3, each wrapping at 16 bits. R(v) adds 8192 to the 32-bit value v, shifts it arithmetically right by 14 and saturates the result to signed 16 bits.
- R6: Inverse ADST on inputs x0..x3, with all products and sums wrapping at 32 bits. Let p = 5283x0 + 15212x2 + 9929x3, q = 9929x0 - 5283x2 - 15212x3 and u = 13377x1. The outputs are y0 = R(p+u), y1 = R(q+u), y2 = R(13377(x0-x2+x3)) and y3 = R(p+q-u).
- R7: Each final residual y becomes (y+8)>>4, using an arithmetic shift. It is added to the unsigned prediction pixel at the same position, and the sum is clamped to 0..255.
- R8: The first pass works on rows, taking inputs in column order 0..3. The second pass works on the columns of the first-pass result, taking inputs in row order 0..3. The output of the second pass for input k is the pixel in row k.
- R9: out_valid rises exactly eight clock edges after the edge that accepts a block (in_valid and in_ready both high).
- R10: in_ready is high only while no block is held. It drops on the edge that accepts a block and returns on the edge after out_valid and out_ready are both high. in_valid is ignored while in_ready is low.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_pix does not change.
- R12: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input block is offered |
| in_ready | output | 1 | Block can accept an input |
| in_type | input | 2 | Transform type code (bit 1 picks the row transform, bit 0 picks the column transform; 1 = ADST) |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, row-major |
| in_pred | input | 128 | Sixteen unsigned 8-bit prediction pixels, row-major |
| out_valid | output | 1 | Reconstructed block is available |
| out_ready | input | 1 | Consumer takes the output block |
| out_pix | output | 128 | Sixteen reconstructed 8-bit pixels, row-major |

## Verification
A DC-only block under type 0 checks the plain DCT path and the final rounding. Mixed-sign blocks under each of the four type codes separate the four pass pairings: a swapped or misrouted transform changes almost every pixel. A single nonzero coefficient off the diagonal under type 1 can only match when rows come first and the transpose is oriented correctly. Blocks filled with the most positive and the most negative coefficients drive the 16-bit wrap and saturation behaviour. Large DC values over bright and dark predictions drive both pixel clamps. The handshake is tested by holding the output back for several cycles and by offering new data while a block is in flight.

// File: rtl/iht4_pkg.sv
package iht4_pkg;
  localparam int PTS   = 4;
  localparam int ELEMS = PTS * PTS;
  localparam int IDX_W = $clog2(PTS);

  // 14-bit fixed-point cosine and sine factors
  localparam int C_DCT_MID = 11585;
  localparam int C_DCT_LO  = 6270;
  localparam int C_DCT_HI  = 15137;
  localparam int C_SIN1    = 5283;
  localparam int C_SIN2    = 9929;
  localparam int C_SIN3    = 13377;
  localparam int C_SIN4    = 15212;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL, ST_DONE} phase_e;

  typedef struct packed {
    logic             load;
    logic             rowWr;
    logic             colWr;
    logic [IDX_W-1:0] idx;
  } strobe_s;
endpackage

// File: rtl/iht4_lane.sv
// One 4-point inverse transform, DCT or ADST, purely combinational.
module iht4_lane
  import iht4_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int FRAC   = 14
) (
  input  logic                     useAdst,
  input  logic signed [COEF_W-1:0] xIn  [PTS],
  output logic signed [COEF_W-1:0] yOut [PTS]
);
  localparam int ACC_W = 2 * COEF_W;
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'(2**(COEF_W-1) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = (ACC_W+1)'(-(2**(COEF_W-1)));
  localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(2**(FRAC-1));
  localparam logic signed [ACC_W-1:0] K_MID = ACC_W'(C_DCT_MID);
  localparam logic signed [ACC_W-1:0] K_LO  = ACC_W'(C_DCT_LO);
  localparam logic signed [ACC_W-1:0] K_HI  = ACC_W'(C_DCT_HI);
  localparam logic signed [ACC_W-1:0] K_S1  = ACC_W'(C_SIN1);
  localparam logic signed [ACC_W-1:0] K_S2  = ACC_W'(C_SIN2);
  localparam logic signed [ACC_W-1:0] K_S3  = ACC_W'(C_SIN3);
  localparam logic signed [ACC_W-1:0] K_S4  = ACC_W'(C_SIN4);

  function automatic logic signed [ACC_W-1:0] ext(input logic signed [COEF_W-1:0] v);
    return ACC_W'(v);
  endfunction

  function automatic logic signed [COEF_W-1:0] rndSat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W:0] t;
    t = ((ACC_W+1)'(v) + HALF) >>> FRAC;
    if (t > SAT_HI)      return COEF_W'(SAT_HI);
    else if (t < SAT_LO) return COEF_W'(SAT_LO);
    else                 return COEF_W'(t);
  endfunction

  logic signed [COEF_W-1:0] sumA, difB;
  logic signed [COEF_W-1:0] d0, d1, d2, d3;
  logic signed [ACC_W-1:0]  aP, aQ, aU, aV;
  logic signed [COEF_W-1:0] dctY [PTS];
  logic signed [COEF_W-1:0] adstY [PTS];

  always_comb begin
    sumA = xIn[0] + xIn[2];
    difB = xIn[0] - xIn[2];
    d0 = rndSat(ext(sumA) * K_MID);
    d1 = rndSat(ext(difB) * K_MID);
    d2 = rndSat(ext(xIn[1]) * K_LO - ext(xIn[3]) * K_HI);
    d3 = rndSat(ext(xIn[1]) * K_HI + ext(xIn[3]) * K_LO);
    dctY[0] = d0 + d3;
    dctY[1] = d1 + d2;
    dctY[2] = d1 - d2;
    dctY[3] = d0 - d3;
  end

  always_comb begin
    aP = ext(xIn[0]) * K_S1 + ext(xIn[2]) * K_S4 + ext(xIn[3]) * K_S2;
    aQ = ext(xIn[0]) * K_S2 - ext(xIn[2]) * K_S1 - ext(xIn[3]) * K_S4;
    aU = ext(xIn[1]) * K_S3;
    aV = (ext(xIn[0]) - ext(xIn[2]) + ext(xIn[3])) * K_S3;
    adstY[0] = rndSat(aP + aU);
    adstY[1] = rndSat(aQ + aU);
    adstY[2] = rndSat(aV);
    adstY[3] = rndSat(aP + aQ - aU);
  end

  always_comb begin
    for (int k = 0; k < PTS; k++) yOut[k] = useAdst ? adstY[k] : dctY[k];
  end
endmodule

// File: rtl/iht4_ctrl.sv
module iht4_ctrl
  import iht4_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_s ctl
);
  localparam int LAT = 2 * PTS;
  localparam int LAT_W = $clog2(LAT + 2);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PTS - 1);

  phase_e           phase;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_IDLE: if (inValid) begin
          phase <= ST_ROW;
          cnt   <= '0;
        end
        ST_ROW: begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == LAST) phase <= ST_COL;
        end
        ST_COL: begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == LAST) phase <= ST_DONE;
        end
        default: if (outReady) phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady   = (phase == ST_IDLE);
    outValid  = (phase == ST_DONE);
    ctl.load  = inReady && inValid;
    ctl.rowWr = (phase == ST_ROW);
    ctl.colWr = (phase == ST_COL);
    ctl.idx   = cnt;
  end

  // cycles elapsed since acceptance, kept only for the latency check
  logic [LAT_W-1:0] sinceAcc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sinceAcc <= '0;
    else if (inReady && inValid) sinceAcc <= '0;
    else if (!inReady && !outValid && sinceAcc != '1) sinceAcc <= sinceAcc + 1'b1;
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> sinceAcc == LAT_W'(LAT));
  a_r10_lock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> !inReady);
  a_r10_no_ready_with_output: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady |=> inReady && !outValid);
endmodule

// File: rtl/iht4_datapath.sv
module iht4_datapath
  import iht4_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8,
  parameter int FRAC   = 14,
  parameter int OUT_SH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobe_s                   ctl,
  input  logic [1:0]                typeIn,
  input  logic [ELEMS*COEF_W-1:0]   coefIn,
  input  logic [ELEMS*PIX_W-1:0]    predIn,
  output logic [ELEMS*PIX_W-1:0]    pixOut
);
  localparam logic signed [COEF_W+1:0] PIX_MAX = (COEF_W+2)'(2**PIX_W - 1);
  localparam logic signed [COEF_W:0]   OUT_HALF = (COEF_W+1)'(2**(OUT_SH-1));

  logic signed [COEF_W-1:0] coefBuf [ELEMS];
  logic signed [COEF_W-1:0] midBuf  [ELEMS];
  logic        [PIX_W-1:0]  predBuf [ELEMS];
  logic        [PIX_W-1:0]  pixBuf  [ELEMS];
  logic        [1:0]        typeReg;

  logic signed [COEF_W-1:0] laneIn  [PTS];
  logic signed [COEF_W-1:0] laneOut [PTS];
  logic        [PIX_W-1:0]  recon   [PTS];
  logic                     useAdst;

  function automatic logic [PIX_W-1:0] clipAdd(input logic signed [COEF_W-1:0] y,
                                                input logic [PIX_W-1:0] p);
    logic signed [COEF_W:0]   r;
    logic signed [COEF_W+1:0] s;
    r = ((COEF_W+1)'(y) + OUT_HALF) >>> OUT_SH;
    s = (COEF_W+2)'(r) + (COEF_W+2)'($signed({1'b0, p}));
    if (s < 0)            return '0;
    else if (s > PIX_MAX) return '1;
    else                  return PIX_W'(s);
  endfunction

  // row pass reads row idx of the coefficients; column pass reads column idx of midBuf
  assign useAdst = ctl.rowWr ? typeReg[1] : typeReg[0];

  for (genvar k = 0; k < PTS; k++) begin : g_lane
    assign laneIn[k] = ctl.rowWr ? coefBuf[{ctl.idx, IDX_W'(k)}]
                                 : midBuf[{IDX_W'(k), ctl.idx}];
    assign recon[k]  = clipAdd(laneOut[k], predBuf[{IDX_W'(k), ctl.idx}]);
  end

  iht4_lane #(.COEF_W(COEF_W), .FRAC(FRAC)) u_lane (
    .useAdst(useAdst),
    .xIn    (laneIn),
    .yOut   (laneOut)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeReg <= '0;
      for (int i = 0; i < ELEMS; i++) begin
        coefBuf[i] <= '0;
        midBuf[i]  <= '0;
        predBuf[i] <= '0;
        pixBuf[i]  <= '0;
      end
    end else begin
      if (ctl.load) begin
        typeReg <= typeIn;
        for (int i = 0; i < ELEMS; i++) begin
          coefBuf[i] <= coefIn[i*COEF_W +: COEF_W];
          predBuf[i] <= predIn[i*PIX_W +: PIX_W];
        end
      end
      if (ctl.rowWr)
        for (int k = 0; k < PTS; k++) midBuf[{ctl.idx, IDX_W'(k)}] <= laneOut[k];
      if (ctl.colWr)
        for (int k = 0; k < PTS; k++) pixBuf[{IDX_W'(k), ctl.idx}] <= recon[k];
    end
  end

  for (genvar i = 0; i < ELEMS; i++) begin : g_out
    assign pixOut[i*PIX_W +: PIX_W] = pixBuf[i];
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.load, ctl.rowWr, ctl.colWr}));
  a_r8_pass_order: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.colWr && ctl.idx == '0 |-> $past(ctl.rowWr));
endmodule

// File: rtl/iht4_recon.sv
module iht4_recon
  import iht4_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8,
  parameter int FRAC   = 14,
  parameter int OUT_SH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               in_type,
  input  logic [ELEMS*COEF_W-1:0]  in_coef,
  input  logic [ELEMS*PIX_W-1:0]   in_pred,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ELEMS*PIX_W-1:0]   out_pix
);
  strobe_s ctl;

  iht4_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (in_valid),
    .outReady(out_ready),
    .inReady (in_ready),
    .outValid(out_valid),
    .ctl     (ctl)
  );

  iht4_datapath #(.COEF_W(COEF_W), .PIX_W(PIX_W), .FRAC(FRAC), .OUT_SH(OUT_SH)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .typeIn(in_type),
    .coefIn(in_coef),
    .predIn(in_pred),
    .pixOut(out_pix)
  );

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));
endmodule

// File: tb/test_iht4_recon.sv
`timescale 1ns/1ps
module test_iht4_recon;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_type = 2'd0;
  logic [255:0] in_coef = '0;
  logic [127:0] in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_pix;

  always #2 clk = ~clk;

  iht4_recon i_iht4_recon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_coef(in_coef), .in_pred(in_pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  bit mReady = 1;
  bit mOutV  = 0;
  int mCnt   = 0;
  int expPix [16];
  string tag = "R12";
  int coefA [16];
  int predA [16];

  function automatic int w16(int v);
    shortint s;
    s = shortint'(v);
    return int'(s);
  endfunction

  function automatic int rnd14(int v);
    longint t;
    t = (longint'(v) + 64'sd8192) >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  task automatic tx1d(input bit adst, input int x [4], output int y [4]);
    if (!adst) begin  // R5
      int a, b, s0, s1, s2, s3;
      a = w16(x[0] + x[2]);
      b = w16(x[0] - x[2]);
      s0 = rnd14(a * 11585);
      s1 = rnd14(b * 11585);
      s2 = rnd14(x[1] * 6270 - x[3] * 15137);
      s3 = rnd14(x[1] * 15137 + x[3] * 6270);
      y[0] = w16(s0 + s3); y[1] = w16(s1 + s2);
      y[2] = w16(s1 - s2); y[3] = w16(s0 - s3);
    end else begin    // R6
      int p, q, u, v;
      p = 5283 * x[0] + 15212 * x[2] + 9929 * x[3];
      q = 9929 * x[0] - 5283 * x[2] - 15212 * x[3];
      u = 13377 * x[1];
      v = 13377 * (x[0] - x[2] + x[3]);
      y[0] = rnd14(p + u); y[1] = rnd14(q + u);
      y[2] = rnd14(v);     y[3] = rnd14(p + q - u);
    end
  endtask

  // R8: rows first, then columns; R7: round, add prediction, clamp
  task automatic modelBlock();
    int mid [16];
    int x [4];
    int y [4];
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) x[k] = int'($signed(in_coef[16*(4*r+k) +: 16]));
      tx1d(in_type[1], x, y);
      for (int k = 0; k < 4; k++) mid[4*r+k] = y[k];
    end
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) x[k] = mid[4*k+c];
      tx1d(in_type[0], x, y);
      for (int k = 0; k < 4; k++) begin
        int s;
        s = ((y[k] + 8) >>> 4) + int'(in_pred[8*(4*k+c) +: 8]);
        expPix[4*k+c] = (s < 0) ? 0 : (s > 255) ? 255 : s;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (in_ready !== mReady) begin
      fails++;
      $display("FAIL R10 in_ready actual=%0b expected=%0b", in_ready, mReady);
    end
    checks++;
    if (out_valid !== mOutV) begin
      fails++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, mOutV);
    end
    if (mOutV) begin
      int bad;
      bad = -1;
      checks++;
      for (int i = 0; i < 16; i++)
        if (bad < 0 && int'(out_pix[8*i +: 8]) != expPix[i]) bad = i;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s pixel %0d actual=%0d expected=%0d", tag, bad,
                 int'(out_pix[8*bad +: 8]), expPix[bad]);
      end
    end
  endtask

  task automatic tick();
    if (mReady && in_valid) begin
      mReady = 0; mCnt = 0; modelBlock();
    end else if (!mReady && !mOutV) begin
      mCnt++;
      if (mCnt == 8) mOutV = 1;
    end else if (mOutV && out_ready) begin
      mOutV = 0; mReady = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic runBlock(input int ty, input string t, input int holdCyc, input bit junk);
    tag = t;
    for (int i = 0; i < 16; i++) begin
      in_coef[16*i +: 16] = 16'(coefA[i]);
      in_pred[8*i +: 8]   = 8'(predA[i]);
    end
    in_type = 2'(ty);
    in_valid = 1;
    out_ready = 0;
    tick();
    if (junk) begin  // R10: new data offered while busy must be ignored
      in_coef = ~in_coef;
      in_pred = ~in_pred;
      in_type = ~in_type;
    end else in_valid = 0;
    while (!mOutV) tick();
    in_valid = 0;
    repeat (holdCyc) tick();
    out_ready = 1;
    tick();
    out_ready = 0;
  endtask

  task automatic fill(input int lo, input int hi, input int plo, input int phi);
    for (int i = 0; i < 16; i++) begin
      coefA[i] = lo + int'($urandom_range(32'(hi - lo)));
      predA[i] = plo + int'($urandom_range(32'(phi - plo)));
    end
  endtask

  task automatic constFill(input int cv, input int pv);
    for (int i = 0; i < 16; i++) begin coefA[i] = cv; predA[i] = pv; end
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare();  // R12 reset state

    constFill(0, 100); coefA[0] = 64;
    runBlock(0, "R1/R5/R7 dc", 0, 0);
    fill(-300, 300, 0, 255);  runBlock(0, "R1/R5", 0, 0);
    fill(-300, 300, 0, 255);  runBlock(1, "R2/R6", 0, 0);
    fill(-300, 300, 0, 255);  runBlock(2, "R3/R6", 0, 0);
    fill(-300, 300, 0, 255);  runBlock(3, "R4/R6", 0, 0);
    constFill(0, 128); coefA[1] = 900;
    runBlock(1, "R8 single", 0, 0);
    constFill(0, 128); coefA[4] = -700;
    runBlock(2, "R8 single", 0, 0);
    constFill(32767, 128);  runBlock(0, "R5 extreme", 0, 0);
    constFill(-32768, 128); runBlock(3, "R6 extreme", 0, 0);
    constFill(0, 250); coefA[0] = 2000;
    runBlock(0, "R7 clamp high", 0, 0);
    constFill(0, 5); coefA[0] = -2000;
    runBlock(0, "R7 clamp low", 0, 0);
    fill(-2000, 2000, 0, 255); runBlock(3, "R11 hold", 6, 0);
    fill(-500, 500, 0, 255);   runBlock(1, "R10 busy input", 2, 1);
    for (int n = 0; n < 8; n++) begin
      fill(-4000, 4000, 0, 255);
      runBlock(n % 4, "R1/R2/R3/R4 sweep", n % 3, n[0]);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule